// File: doc/BRIEF.md
# Serial Flash Region Erase/Program/Verify Sequencer

This block walks a serial flash region through erase or program operations, and reads every unit back and compares it in hardware. A host pulses `start` with a base address, a byte count and a direction flag. The block then issues single commands, one at a time, to a downstream serial command engine. For each unit it sends a write-enable, then either a sector erase or a page program, then a status poll that waits for the busy bit to clear. It ends each unit with a read-back. The engine moves the bytes on the pins. This block only chooses the opcode, the address, the length and the direction of each command, and it sources or checks the data bytes.

Program data arrives on a ready/valid byte stream. Each page is first collected in a local page buffer. That buffer feeds the program data phase and also provides the expected bytes for the read-back, so the source never sends anything twice. A short last page is completed with zero bytes. For an erase, every read-back byte must equal 0xFF.

The outcome is a one-cycle `done` pulse with a 2-bit `result`. A successful program run first pulses `mm_load`, which hands the flash back for memory-mapped reads using the plain read opcode.

Top module: `flash_region_ctl`

## Requirements
- R1: A start whose address is not a multiple of SECTOR_BYTES produces `done` on the next cycle with `result` = 1 (alignment error). No sequencer command is issued.
- R2: Each unit begins with opcode 0x06 and 0 address bytes. The unit's second command comes next. After it comes opcode 0x05 with `sq_poll`=1, `sq_poll_bit`=0, `sq_poll_set`=0 (wait for bit 0 clear) and 0 address bytes. Any byte returned during the poll is discarded.
- R3: An erase unit uses opcode 0x20 with 3 address bytes at the sector address. Its read-back uses opcode 0x03 with 3 address bytes and length SECTOR_BYTES. Any read-back byte other than 0xFF ends the run with `result` = 2.
- R4: An erase of L > 0 bytes covers ceil(L / SECTOR_BYTES) sectors at consecutive sector addresses. A count of exactly k·SECTOR_BYTES covers k sectors.
- R5: A program unit uses opcode 0x02 with 3 address bytes, `sq_dout`=1 and length PAGE_BYTES. It delivers exactly PAGE_BYTES bytes on the tx stream. A program of L > 0 bytes covers ceil(L / PAGE_BYTES) pages.
- R6: Exactly L bytes are taken from the write stream. The bytes of the last page beyond L are programmed as 0x00.
- R7: Each page is read back with opcode 0x03, 3 address bytes and length PAGE_BYTES. A mismatch ends the run with `result` = 2 after that page. No further pages are processed and `mm_load` is not pulsed.
- R8: A successful program run, including one with L = 0, pulses `mm_load` once, with `mm_opcode` = 0x03 and `mm_addr_bytes` = 3, in the cycle before `done`.
- R9: After reset, `busy`, `done`, `wr_ready`, `sq_start` and `mm_load` are low. `busy` is high from the cycle after an accepted start until `done`. `done` lasts one cycle, and `result` = 0 means success.
- R10: A `start` while `busy` is high has no effect on the running operation.
- R11: An erase with L = 0 finishes with `result` = 0 and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken when idle |
| op_write | input | 1 | 1 = program, 0 = erase |
| start_addr | input | ADDR_W | Region base address |
| length | input | LEN_W | Region length in bytes |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program data accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 alignment error, 2 verify failure |
| sq_start | output | 1 | Command launch pulse to the serial engine |
| sq_opcode | output | 8 | Command opcode |
| sq_addr | output | ADDR_W | Command address |
| sq_addr_bytes | output | 3 | Number of address bytes sent |
| sq_len | output | SQ_LEN_W | Data phase length in bytes |
| sq_dout | output | 1 | Data phase direction, 1 = to flash |
| sq_poll | output | 1 | Repeat status read until the condition holds |
| sq_poll_bit | output | 3 | Status bit examined when polling |
| sq_poll_set | output | 1 | Poll condition: 1 = bit set, 0 = bit clear |
| sq_done | input | 1 | Command finished pulse from the engine |
| sq_tx_data | output | 8 | Program data byte to the engine |
| sq_tx_valid | output | 1 | Program data byte valid |
| sq_tx_ready | input | 1 | Engine accepts a program byte |
| sq_rx_data | input | 8 | Byte read from flash |
| sq_rx_valid | input | 1 | Read byte valid |
| mm_load | output | 1 | Pulse: switch the engine to memory-mapped read |
| mm_opcode | output | 8 | Opcode for memory-mapped reads |
| mm_addr_bytes | output | 3 | Address bytes for memory-mapped reads |

## Verification
The bench builds the block with SECTOR_BYTES = 64, PAGE_BYTES = 16 and 16-bit address and length. One sector then holds four pages, and the bench's 1 KiB flash model can host several erase and program runs in a few thousand cycles. With these sizes the tests reach multi-sector erases, exact-multiple and ragged program lengths with zero padding, re-programming without erase (which exposes the verify path through AND-style flash writes), and a sector that cannot be erased. Default sizes only change counter widths and buffer depth.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FILL,
      ST_WEN_GO,
      ST_WEN_WAIT,
      ST_MOD_GO,
      ST_MOD_WAIT,
      ST_POLL_GO,
      ST_POLL_WAIT,
      ST_RB_GO,
      ST_RB_WAIT,
      ST_NEXT,
      ST_MAP,
      ST_END
   } fc_state_t;

   localparam logic [1:0] RES_OK     = 2'd0;
   localparam logic [1:0] RES_ALIGN  = 2'd1;
   localparam logic [1:0] RES_VERIFY = 2'd2;

   localparam logic [7:0] OPC_WREN   = 8'h06;
   localparam logic [7:0] OPC_SERASE = 8'h20;
   localparam logic [7:0] OPC_RDSR   = 8'h05;
   localparam logic [7:0] OPC_PROG   = 8'h02;
   localparam logic [7:0] OPC_READ   = 8'h03;

endpackage

// File: rtl/fc_page_buf.sv
module fc_page_buf #(
   parameter int PAGE_BYTES = 256,
   localparam int AW   = $clog2(PAGE_BYTES),
   localparam int PG_W = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push,
   input  logic [7:0]      push_data,
   output logic [PG_W-1:0] fill,
   input  logic [PG_W-1:0] rd_idx,
   output logic [7:0]      rd_data
);

   generate
      if (PAGE_BYTES < 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("fc_page_buf: PAGE_BYTES must be a power of two, at least 4");
      end
   endgenerate

   logic [7:0] mem [PAGE_BYTES];

   always_ff @(posedge clk) begin
      if (push) mem[fill[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fill <= '0;
      else if (clr)   fill <= '0;
      else if (push)  fill <= fill + 1'b1;
   end

   // bytes never loaded read as zero: this is the short-page padding
   assign rd_data = (rd_idx < fill) ? mem[rd_idx[AW-1:0]] : 8'h00;

   AST_BUF_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (fill < PG_W'(PAGE_BYTES))); // R6

endmodule

// File: rtl/fc_region_walk.sv
module fc_region_walk #(
   parameter int ADDR_W       = 24,
   parameter int LEN_W        = 24,
   parameter int SECTOR_BYTES = 4096,
   parameter int PAGE_BYTES   = 256,
   localparam int PG_W = $clog2(PAGE_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic              is_write,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  rem,
   output logic              last,
   output logic [PG_W-1:0]   take
);

   localparam logic [LEN_W-1:0] PAGE_L   = LEN_W'(PAGE_BYTES);
   localparam logic [LEN_W-1:0] SECTOR_L = LEN_W'(SECTOR_BYTES);

   generate
      if (LEN_W < $clog2(SECTOR_BYTES) + 1) begin : g_bad_len
         $error("fc_region_walk: LEN_W too narrow for one sector");
      end
   endgenerate

   logic [LEN_W-1:0] unit;

   assign unit = is_write ? PAGE_L : SECTOR_L;
   assign last = (rem <= unit);
   assign take = (rem < PAGE_L) ? rem[PG_W-1:0] : PG_W'(PAGE_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         rem  <= '0;
      end else if (load) begin
         addr <= base;
         rem  <= len;
      end else if (step) begin
         addr <= addr + ADDR_W'(unit);
         rem  <= rem - unit;
      end
   end

   AST_STEP_HAS_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (rem > unit)); // R4

endmodule

// File: rtl/fc_cmp.sv
module fc_cmp (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] got,
   input  logic [7:0] want,
   output logic       bad
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bad <= 1'b0;
      else if (clr)                  bad <= 1'b0;
      else if (en && (got != want))  bad <= 1'b1;
   end

   AST_MISMATCH_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && (got != want)) |=> bad); // R3

endmodule

// File: rtl/flash_region_ctl.sv
module flash_region_ctl
   import flash_ctl_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int LEN_W        = 24,
   parameter int SECTOR_BYTES = 4096,
   parameter int PAGE_BYTES   = 256,
   localparam int SQ_LEN_W    = $clog2(SECTOR_BYTES) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                op_write,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic [LEN_W-1:0]    length,
   input  logic [7:0]          wr_data,
   input  logic                wr_valid,
   output logic                wr_ready,
   output logic                busy,
   output logic                done,
   output logic [1:0]          result,
   output logic                sq_start,
   output logic [7:0]          sq_opcode,
   output logic [ADDR_W-1:0]   sq_addr,
   output logic [2:0]          sq_addr_bytes,
   output logic [SQ_LEN_W-1:0] sq_len,
   output logic                sq_dout,
   output logic                sq_poll,
   output logic [2:0]          sq_poll_bit,
   output logic                sq_poll_set,
   input  logic                sq_done,
   output logic [7:0]          sq_tx_data,
   output logic                sq_tx_valid,
   input  logic                sq_tx_ready,
   input  logic [7:0]          sq_rx_data,
   input  logic                sq_rx_valid,
   output logic                mm_load,
   output logic [7:0]          mm_opcode,
   output logic [2:0]          mm_addr_bytes
);

   localparam int SEC_AW = $clog2(SECTOR_BYTES);
   localparam int PG_W   = $clog2(PAGE_BYTES) + 1;
   localparam int IDX_W  = SQ_LEN_W;

   generate
      if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || PAGE_BYTES > SECTOR_BYTES) begin : g_bad_geom
         $error("flash_region_ctl: sector must be a power of two no smaller than a page");
      end
      if (ADDR_W <= SEC_AW) begin : g_bad_addr
         $error("flash_region_ctl: ADDR_W must exceed the sector offset width");
      end
   endgenerate

   fc_state_t        state;
   logic             wr_q;
   logic [1:0]       res_q;
   logic [IDX_W-1:0] idx_q;

   logic              misaligned;
   logic              walk_load, walk_step, walk_last;
   logic [ADDR_W-1:0] walk_addr;
   logic [LEN_W-1:0]  walk_rem;
   logic [PG_W-1:0]   walk_take, buf_fill;
   logic [7:0]        buf_byte, want_byte;
   logic              buf_clr, buf_push;
   logic              cmp_clr, cmp_en, cmp_bad;
   logic              tx_fire;

   assign misaligned = |start_addr[SEC_AW-1:0];
   assign walk_load  = (state == ST_IDLE) && start;
   assign walk_step  = (state == ST_NEXT) && !cmp_bad && !walk_last;
   assign buf_clr    = walk_load || walk_step;
   assign wr_ready   = (state == ST_FILL) && (buf_fill < walk_take);
   assign buf_push   = wr_ready && wr_valid;
   assign cmp_clr    = (state == ST_RB_GO);
   assign cmp_en     = (state == ST_RB_WAIT) && sq_rx_valid;
   assign want_byte  = wr_q ? buf_byte : 8'hFF;

   assign sq_tx_valid = (state == ST_MOD_WAIT) && wr_q && (idx_q < IDX_W'(PAGE_BYTES));
   assign sq_tx_data  = buf_byte;
   assign tx_fire     = sq_tx_valid && sq_tx_ready;

   fc_region_walk #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .SECTOR_BYTES(SECTOR_BYTES), .PAGE_BYTES(PAGE_BYTES)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .load(walk_load), .base(start_addr), .len(length),
      .is_write(wr_q), .step(walk_step), .addr(walk_addr), .rem(walk_rem),
      .last(walk_last), .take(walk_take)
   );

   fc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push), .push_data(wr_data),
      .fill(buf_fill), .rd_idx(idx_q[PG_W-1:0]), .rd_data(buf_byte)
   );

   fc_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(cmp_en),
      .got(sq_rx_data), .want(want_byte), .bad(cmp_bad)
   );

   // command fields are a pure function of the phase
   always_comb begin
      sq_opcode     = OPC_WREN;
      sq_addr_bytes = 3'd0;
      sq_len        = '0;
      sq_dout       = 1'b0;
      sq_poll       = 1'b0;
      sq_poll_bit   = 3'd0;
      sq_poll_set   = 1'b0;
      unique case (state)
         ST_MOD_GO, ST_MOD_WAIT: begin
            sq_opcode     = wr_q ? OPC_PROG : OPC_SERASE;
            sq_addr_bytes = 3'd3;
            sq_len        = wr_q ? SQ_LEN_W'(PAGE_BYTES) : '0;
            sq_dout       = wr_q;
         end
         ST_POLL_GO, ST_POLL_WAIT: begin
            sq_opcode = OPC_RDSR;
            sq_poll   = 1'b1;
         end
         ST_RB_GO, ST_RB_WAIT: begin
            sq_opcode     = OPC_READ;
            sq_addr_bytes = 3'd3;
            sq_len        = wr_q ? SQ_LEN_W'(PAGE_BYTES) : SQ_LEN_W'(SECTOR_BYTES);
         end
         default: ;
      endcase
   end

   assign sq_addr  = walk_addr;
   assign sq_start = (state == ST_WEN_GO) || (state == ST_MOD_GO) ||
                     (state == ST_POLL_GO) || (state == ST_RB_GO);

   assign mm_load       = (state == ST_MAP);
   assign mm_opcode     = OPC_READ;
   assign mm_addr_bytes = 3'd3;

   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_END);
   assign result = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (sq_start) begin
         idx_q <= '0;
      end else if (tx_fire || cmp_en) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wr_q  <= 1'b0;
         res_q <= RES_OK;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               wr_q <= op_write;
               if (misaligned) begin
                  res_q <= RES_ALIGN;
                  state <= ST_END;
               end else begin
                  res_q <= RES_OK;
                  if (length == '0) state <= op_write ? ST_MAP  : ST_END;
                  else              state <= op_write ? ST_FILL : ST_WEN_GO;
               end
            end
            ST_FILL:      if (buf_fill == walk_take) state <= ST_WEN_GO;
            ST_WEN_GO:    state <= ST_WEN_WAIT;
            ST_WEN_WAIT:  if (sq_done) state <= ST_MOD_GO;
            ST_MOD_GO:    state <= ST_MOD_WAIT;
            ST_MOD_WAIT:  if (sq_done) state <= ST_POLL_GO;
            ST_POLL_GO:   state <= ST_POLL_WAIT;
            ST_POLL_WAIT: if (sq_done) state <= ST_RB_GO;
            ST_RB_GO:     state <= ST_RB_WAIT;
            ST_RB_WAIT:   if (sq_done) state <= ST_NEXT;
            ST_NEXT: begin
               if (cmp_bad) begin
                  res_q <= RES_VERIFY;
                  state <= ST_END;
               end else if (walk_last) begin
                  state <= wr_q ? ST_MAP : ST_END;
               end else begin
                  state <= wr_q ? ST_FILL : ST_WEN_GO;
               end
            end
            ST_MAP:  state <= ST_END;
            ST_END:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && misaligned) |=> (done && result == RES_ALIGN)); // R1
   AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sq_start |=> !sq_start); // R2
   AST_TX_ONLY_IN_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
      sq_tx_valid |-> (sq_opcode == OPC_PROG && sq_dout)); // R5
   AST_MAP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      mm_load |=> (done && result == RES_OK)); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R10

endmodule

// File: tb/sim_flash_region_ctl.sv
module sim_flash_region_ctl;

   localparam int AW   = 16;
   localparam int LW   = 16;
   localparam int SECT = 64;
   localparam int PAGE = 16;
   localparam int SLW  = $clog2(SECT) + 1;
   localparam int MEMSZ = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic           start = 1'b0, op_write = 1'b0;
   logic [AW-1:0]  start_addr = '0;
   logic [LW-1:0]  length = '0;
   logic [7:0]     wr_data = '0;
   logic           wr_valid = 1'b0, wr_ready;
   logic           busy, done;
   logic [1:0]     result;
   logic           sq_start, sq_dout, sq_poll, sq_poll_set;
   logic [7:0]     sq_opcode, sq_tx_data;
   logic [AW-1:0]  sq_addr;
   logic [2:0]     sq_addr_bytes, sq_poll_bit, mm_addr_bytes;
   logic [SLW-1:0] sq_len;
   logic           sq_done = 1'b0, sq_tx_valid, sq_tx_ready = 1'b0;
   logic [7:0]     sq_rx_data = '0;
   logic           sq_rx_valid = 1'b0;
   logic           mm_load;
   logic [7:0]     mm_opcode;

   flash_region_ctl #(.ADDR_W(AW), .LEN_W(LW), .SECTOR_BYTES(SECT), .PAGE_BYTES(PAGE)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
      .start_addr(start_addr), .length(length), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .busy(busy), .done(done), .result(result),
      .sq_start(sq_start), .sq_opcode(sq_opcode), .sq_addr(sq_addr),
      .sq_addr_bytes(sq_addr_bytes), .sq_len(sq_len), .sq_dout(sq_dout),
      .sq_poll(sq_poll), .sq_poll_bit(sq_poll_bit), .sq_poll_set(sq_poll_set),
      .sq_done(sq_done), .sq_tx_data(sq_tx_data), .sq_tx_valid(sq_tx_valid),
      .sq_tx_ready(sq_tx_ready), .sq_rx_data(sq_rx_data), .sq_rx_valid(sq_rx_valid),
      .mm_load(mm_load), .mm_opcode(mm_opcode), .mm_addr_bytes(mm_addr_bytes)
   );

   int n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input int s);
      return 8'(k * 7 + s + 1);
   endfunction

   // ---------------- flash model + command log ----------------
   logic [7:0] fmem [MEMSZ];
   bit         wel = 0;
   bit         stuck_en = 0;
   int         stuck_addr = 0;
   int         n_cmd = 0;
   logic [7:0] lg_op   [64];
   logic [2:0] lg_ab   [64];
   int         lg_addr [64];
   int         lg_len  [64];
   bit         lg_dout [64];
   bit         lg_pok  [64];

   initial begin
      for (int i = 0; i < MEMSZ; i++) fmem[i] = 8'h00;
      forever begin
         @(negedge clk);
         sq_done = 1'b0;
         sq_rx_valid = 1'b0;
         if (sq_start) begin
            automatic logic [7:0] op = sq_opcode;
            automatic int a = int'(sq_addr);
            automatic int n = int'(sq_len);
            if (n_cmd < 64) begin
               lg_op[n_cmd] = op; lg_ab[n_cmd] = sq_addr_bytes; lg_addr[n_cmd] = a;
               lg_len[n_cmd] = n; lg_dout[n_cmd] = sq_dout;
               lg_pok[n_cmd] = sq_poll && sq_poll_bit == 3'd0 && !sq_poll_set;
            end
            n_cmd++;
            case (op)
               8'h06: begin @(negedge clk); wel = 1; sq_done = 1'b1; end
               8'h20: begin
                  @(negedge clk);
                  if (wel) for (int i = 0; i < SECT; i++) begin
                     automatic int m = ((a & ~(SECT - 1)) + i) % MEMSZ;
                     fmem[m] = (stuck_en && m == stuck_addr) ? 8'h00 : 8'hFF;
                  end
                  wel = 0; sq_done = 1'b1;
               end
               8'h02: begin
                  automatic int c = 0;
                  sq_tx_ready = 1'b1;
                  while (c < n) begin
                     @(negedge clk);
                     if (sq_tx_valid) begin
                        if (wel) fmem[(a + c) % MEMSZ] = fmem[(a + c) % MEMSZ] & sq_tx_data;
                        c++;
                     end
                  end
                  @(negedge clk);
                  sq_tx_ready = 1'b0; wel = 0; sq_done = 1'b1;
               end
               8'h05: begin
                  repeat (3) @(negedge clk);
                  sq_rx_valid = 1'b1; sq_rx_data = 8'h00;
                  @(negedge clk);
                  sq_rx_valid = 1'b0; sq_done = 1'b1;
               end
               8'h03: begin
                  for (int i = 0; i < n; i++) begin
                     @(negedge clk);
                     sq_rx_valid = 1'b1; sq_rx_data = fmem[(a + i) % MEMSZ];
                  end
                  @(negedge clk);
                  sq_rx_valid = 1'b0; sq_done = 1'b1;
               end
               default: begin @(negedge clk); sq_done = 1'b1; end
            endcase
         end
      end
   end

   // ---------------- write stream feeder and monitors ----------------
   int  feed_k = 0, cur_seed = 0;
   bit  hs_pend = 0;
   int  done_cnt = 0, mm_cnt = 0;
   bit  mm_fields_ok = 1;

   initial forever begin
      @(negedge clk);
      if (hs_pend) feed_k++;
      wr_data  = pat(feed_k, cur_seed);
      wr_valid = 1'b1;
      hs_pend  = wr_ready;
      if (done) done_cnt++;
      if (mm_load) begin
         mm_cnt++;
         if (mm_opcode != 8'h03 || mm_addr_bytes != 3'd3) mm_fields_ok = 0;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   logic [1:0] res_seen;

   task automatic run_op(input bit wr, input int addr, input int len, input int seed);
      bit got = 0;
      cur_seed = seed; feed_k = 0; n_cmd = 0;
      @(negedge clk);
      start = 1'b1; op_write = wr; start_addr = AW'(addr); length = LW'(len);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 20000 && !got; c++) begin
         if (done) begin got = 1; res_seen = result; end
         else @(negedge clk);
      end
      chk(got, "R9 done reached", int'(got), 1);
      repeat (3) @(negedge clk);
   endtask

   // sequence check: commands of units [0, units) follow the required pattern
   function automatic bit seq_ok(input bit wr, input int base, input int units);
      int step = wr ? PAGE : SECT;
      for (int u = 0; u < units; u++) begin
         int k = 4 * u;
         if (lg_op[k] != 8'h06 || lg_ab[k] != 3'd0) return 0;
         if (lg_op[k+1] != (wr ? 8'h02 : 8'h20) || lg_ab[k+1] != 3'd3 ||
             lg_addr[k+1] != base + u * step) return 0;
         if (wr && (lg_len[k+1] != PAGE || !lg_dout[k+1])) return 0;
         if (lg_op[k+2] != 8'h05 || !lg_pok[k+2] || lg_ab[k+2] != 3'd0) return 0;
         if (lg_op[k+3] != 8'h03 || lg_ab[k+3] != 3'd3 ||
             lg_addr[k+3] != base + u * step || lg_len[k+3] != step) return 0;
      end
      return 1;
   endfunction

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] len;
      logic [1:0]  res;
      logic [3:0]  units;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 16'd0,   16'd100, 2'd0, 4'd2},  // R4 two sectors, ragged
      '{1'b1, 16'd0,   16'd40,  2'd0, 4'd3},  // R6 padded last page
      '{1'b0, 16'd128, 16'd64,  2'd0, 4'd1},  // R4 exact sector
      '{1'b1, 16'd128, 16'd64,  2'd0, 4'd4},  // R5 exact pages
      '{1'b0, 16'd33,  16'd10,  2'd1, 4'd0},  // R1 misaligned
      '{1'b1, 16'd0,   16'd16,  2'd2, 4'd1},  // R7 reprogram without erase
      '{1'b0, 16'd0,   16'd0,   2'd0, 4'd0},  // R11 empty erase
      '{1'b1, 16'd64,  16'd0,   2'd0, 4'd0}   // R8 empty write
   };

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !wr_ready && !sq_start && !mm_load, "R9 reset outputs",
          int'({busy, done, wr_ready, sq_start, mm_load}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         automatic vec_t t = VEC[v];
         automatic int mm0 = mm_cnt;
         automatic int d0 = done_cnt;
         automatic bit mem_ok = 1;
         run_op(t.wr, int'(t.addr), int'(t.len), v);
         chk(res_seen == t.res, "R1/R7/R9 result code", int'(res_seen), int'(t.res));
         chk(n_cmd == 4 * int'(t.units), "R4/R5/R11 command count", n_cmd, 4 * int'(t.units));
         chk(seq_ok(t.wr, int'(t.addr), int'(t.units)), "R2/R3/R5 command sequence", 0, 1);
         chk(done_cnt == d0 + 1, "R9 single done pulse", done_cnt - d0, 1);
         chk(mm_cnt - mm0 == ((t.wr && t.res == 2'd0) ? 1 : 0), "R8/R7 memory-mode handoff",
             mm_cnt - mm0, (t.wr && t.res == 2'd0) ? 1 : 0);
         if (t.wr && t.res != 2'd1)
            chk(feed_k == int'(t.len), "R6 bytes taken from stream", feed_k, int'(t.len));
         if (t.res == 2'd0 && t.units != 0) begin
            for (int i = 0; i < int'(t.units) * (t.wr ? PAGE : SECT); i++) begin
               automatic logic [7:0] e = !t.wr ? 8'hFF : (i < int'(t.len) ? pat(i, v) : 8'h00);
               if (fmem[int'(t.addr) + i] != e) mem_ok = 0;
            end
            chk(mem_ok, "R4/R6 flash contents", 0, 1);
         end
      end
      chk(mm_fields_ok, "R8 memory-mode fields", int'(mm_fields_ok), 1);

      // R3: a sector byte that will not erase
      stuck_en = 1; stuck_addr = 256 + 5;
      run_op(1'b0, 256, 128, 0);
      chk(res_seen == 2'd2, "R3 erase verify failure", int'(res_seen), 2);
      chk(n_cmd == 4, "R3 stop after failing sector", n_cmd, 4);
      stuck_en = 0;

      // R10: start during a running erase is ignored
      begin
         automatic int d0 = done_cnt;
         cur_seed = 0; n_cmd = 0;
         @(negedge clk);
         start = 1'b1; op_write = 1'b0; start_addr = 16'd320; length = 16'd64;
         @(negedge clk);
         start = 1'b0;
         repeat (5) @(negedge clk);
         chk(busy, "R9 busy during operation", int'(busy), 1);
         start = 1'b1; start_addr = 16'd3; length = 16'd5;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         chk(!done && busy, "R10 start while busy ignored", int'(done), 0);
         for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
         chk(result == 2'd0, "R10 original result", int'(result), 0);
         repeat (3) @(negedge clk);
         chk(n_cmd == 4 && done_cnt == d0 + 1, "R10 one operation only", n_cmd, 4);
         chk(fmem[320] == 8'hFF && fmem[383] == 8'hFF, "R10 sector erased", int'(fmem[320]), 255);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule